// File: doc/BRIEF.md
# Supply-Fail Monitor Control Register

This block is a 16-bit power-control register, together with the logic that uses its fields. It sits on a simple CPU register bus with a write strobe, a read strobe and 16-bit data. Two supply comparators feed it. One flags that the supply has dropped below a warning threshold. The other flags that the supply has dropped below the reset level. A stop-mode indicator tells the block when the device is in its low-power state.

From these inputs the block produces four outputs:
- a regulator-enable output,
- a comparator-enable output for the monitoring circuitry,
- an interrupt request for the low-supply warning,
- a reset request when the supply falls below the reset level.

The register holds four control fields: a monitor-disable bit, an interrupt-enable bit, a sticky warning flag and a stop-mode regulator-keep bit. Both comparator inputs pass through a synchronizer before use. While the warning comparator is reporting low supply, a software clear of the warning flag does not take effect. The interrupt request depends only on the flag and the interrupt-enable bit. In stop mode the monitor is turned off only when the regulator is also off and monitoring is disabled.

Top module: `pfmon_ctl`

## Requirements
- R1: After reset, the monitor-disable, interrupt-enable, warning-flag and regulator-keep bits are 0. With rd_en high, rd_data reads 16'h0060 with stat_in placed at bits 9:7.
- R2: Bit positions:
  - bit 0 is monitor-disable;
  - bit 1 is interrupt-enable;
  - bit 2 is the warning flag;
  - bit 3 is regulator-keep.

  A write with wr_en high updates these bits from wr_data on the next rising edge. rd_data returns the register while rd_en is 1 and reads 0 while rd_en is 0.
- R3: warn_raw passes through two synchronizer flops. With monitoring active, the flag (rd_data[2]) reads 1 after the third rising edge following warn_raw going high, and still reads 0 after the second.
- R4: Writing 0 to bit 2 clears the flag only when the synchronized warning is absent. While the warning is present, including in the same cycle as the write, the flag stays 1. With no write and no warning, the flag holds its value.
- R5: Writing 1 to bit 2 sets the flag, and an interrupt is raised when bit 1 is 1.
- R6: irq_o equals flag AND interrupt-enable. No other enable affects it.
- R7: reg_en_o is 1 whenever stop_mode is 0. While stop_mode is 1, reg_en_o equals bit 3.
- R8: cmp_en_o is 1 whenever reg_en_o is 1. Otherwise cmp_en_o is the inverse of bit 0.
- R9: pf_rst_o equals cmp_en_o AND the synchronized rlvl_raw, which lags rlvl_raw by two rising edges.
- R10: While cmp_en_o is 0, warn_raw cannot set the flag.
- R11: Writes to bits 15:4 have no effect. On a read:
  - bits 15:10 read 0;
  - bit 4 reads 0;
  - bits 6:5 read 1;
  - bits 9:7 reflect stat_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, 0 when rd_en is low |
| stop_mode | input | 1 | Device is in stop mode |
| warn_raw | input | 1 | Supply below warning threshold (asynchronous) |
| rlvl_raw | input | 1 | Supply below reset level (asynchronous) |
| stat_in | input | 3 | Status value shown in bits 9:7 |
| reg_en_o | output | 1 | Regulator enable |
| cmp_en_o | output | 1 | Monitor comparator enable |
| irq_o | output | 1 | Supply-warning interrupt request |
| pf_rst_o | output | 1 | Supply-fail reset request |

## Verification
Two situations are hardest to reach from the ports.

The first is a warning that arrives while the monitor is gated off and that must then take effect once it is re-enabled. The stimulus holds warn_raw high for several cycles in stop mode with the regulator off and monitoring disabled, confirms that the flag stays 0, and then leaves stop mode. The flag must then set one edge later, because the synchronizer has already settled.

The second is a software clear that collides with a live warning. The bench issues clear writes while the synchronized warning is still high, and again after it has dropped, and checks the flag at each step.

// File: rtl/pfmon_pkg.sv
package pfmon_pkg;
  localparam int REG_W    = 16;
  localparam int STAT_W   = 3;
  localparam int STAT_LSB = 7;
  localparam int DIS_BIT  = 0;
  localparam int IE_BIT   = 1;
  localparam int FLG_BIT  = 2;
  localparam int KEEP_BIT = 3;

  typedef struct packed {
    logic keep;
    logic flag;
    logic ie;
    logic dis;
  } ctl_t;

  // Next flag value: hardware setting wins over any software write.
  function automatic logic flag_next(logic hw_set, logic sw_wr,
                                     logic sw_val, logic cur);
    if (hw_set)     return 1'b1;
    else if (sw_wr) return sw_val;
    else            return cur;
  endfunction

  function automatic logic reg_on(logic stop, logic keep);
    return !stop || keep;
  endfunction

  function automatic logic mon_on(logic reg_is_on, logic dis);
    return reg_is_on || !dis;
  endfunction

  function automatic logic [REG_W-1:0] pack_read(ctl_t c,
                                                 logic [STAT_W-1:0] st);
    logic [REG_W-1:0] v;
    v = '0;
    v[DIS_BIT]  = c.dis;
    v[IE_BIT]   = c.ie;
    v[FLG_BIT]  = c.flag;
    v[KEEP_BIT] = c.keep;
    v[5] = 1'b1;
    v[6] = 1'b1;
    v[STAT_LSB +: STAT_W] = st;
    return v;
  endfunction
endpackage

// File: rtl/pfmon_sync.sv
module pfmon_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfmon_flag.sv
module pfmon_flag
  import pfmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_wr,
  input  logic sw_val,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(hw_set, sw_wr, sw_val, flag_q);
  end

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag_q); // R4
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !sw_val && !hw_set) |=> !flag_q); // R4
  AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_val) |=> flag_q); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !hw_set) |=> $stable(flag_q)); // R4
endmodule

// File: rtl/pfmon_gate.sv
module pfmon_gate
  import pfmon_pkg::*;
(
  input  logic stop_mode,
  input  logic keep_bit,
  input  logic dis_bit,
  input  logic warn_s,
  input  logic rlvl_s,
  output logic reg_en,
  output logic mon_en,
  output logic warn_evt,
  output logic rst_req
);
  always_comb begin
    reg_en   = reg_on(stop_mode, keep_bit);
    mon_en   = mon_on(reg_en, dis_bit);
    warn_evt = mon_en && warn_s;
    rst_req  = mon_en && rlvl_s;
  end
endmodule

// File: rtl/pfmon_ctl.sv
module pfmon_ctl
  import pfmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              stop_mode,
  input  logic              warn_raw,
  input  logic              rlvl_raw,
  input  logic [STAT_W-1:0] stat_in,
  output logic              reg_en_o,
  output logic              cmp_en_o,
  output logic              irq_o,
  output logic              pf_rst_o
);
  ctl_t       ctl;
  logic [1:0] cmp_s;
  logic       warn_evt;
  logic       flag_q;
  logic       unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:KEEP_BIT+1];

  pfmon_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({rlvl_raw, warn_raw}), .q(cmp_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl.dis  <= 1'b0;
      ctl.ie   <= 1'b0;
      ctl.keep <= 1'b0;
    end else if (wr_en) begin
      ctl.dis  <= wr_data[DIS_BIT];
      ctl.ie   <= wr_data[IE_BIT];
      ctl.keep <= wr_data[KEEP_BIT];
    end
  end

  pfmon_gate u_gate (
    .stop_mode(stop_mode), .keep_bit(ctl.keep), .dis_bit(ctl.dis),
    .warn_s(cmp_s[0]), .rlvl_s(cmp_s[1]),
    .reg_en(reg_en_o), .mon_en(cmp_en_o), .warn_evt(warn_evt),
    .rst_req(pf_rst_o)
  );

  pfmon_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hw_set(warn_evt),
    .sw_wr(wr_en), .sw_val(wr_data[FLG_BIT]), .flag_q(flag_q)
  );

  assign ctl.flag = flag_q;
  assign irq_o    = ctl.flag && ctl.ie;
  assign rd_data  = rd_en ? pack_read(ctl, stat_in) : '0;

  AST_IE_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[IE_BIT]) |=> !irq_o); // R6
  AST_RUN_REG_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_mode |-> reg_en_o); // R7
  AST_CMP_FOLLOWS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en_o |-> cmp_en_o); // R8
  AST_STOP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !ctl.keep && ctl.dis) |-> !cmp_en_o); // R8
  AST_NO_RST_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en_o |-> !pf_rst_o); // R9
  AST_OFF_WARN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en_o && !flag_q && !wr_en) |=> !flag_q); // R10
  AST_RSVD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_data[REG_W-1:10] == '0 && rd_data[6:4] == 3'b110)); // R11
endmodule

// File: tb/pfmon_ctl_test.sv
`timescale 1ns/1ps
module pfmon_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en, stop_mode, warn_raw, rlvl_raw;
  logic [15:0] wr_data, rd_data;
  logic [2:0]  stat_in;
  logic        reg_en_o, cmp_en_o, irq_o, pf_rst_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pfmon_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .stop_mode(stop_mode),
    .warn_raw(warn_raw), .rlvl_raw(rlvl_raw), .stat_in(stat_in),
    .reg_en_o(reg_en_o), .cmp_en_o(cmp_en_o), .irq_o(irq_o),
    .pf_rst_o(pf_rst_o)
  );

  // {stop, keep, dis, expected reg_en, expected cmp_en}
  localparam logic [4:0] VEC [8] = '{
    5'b000_11, 5'b001_11, 5'b010_11, 5'b011_11,
    5'b100_01, 5'b101_00, 5'b110_11, 5'b111_11
  };

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [15:0] exp_rd(logic keep, logic flag, logic ie,
                                         logic dis, logic [2:0] st);
    return {6'b0, st, 3'b110, keep, flag, ie, dis};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b1; wr_data = '0;
    stop_mode = 1'b0; warn_raw = 1'b0; rlvl_raw = 1'b0; stat_in = 3'b101;
    tick(3);
    chk("R1 reset read", rd_data, 16'h02E0);
    chk("R1 reset irq/rst", {14'b0, irq_o, pf_rst_o}, 16'h0);
    rst_n = 1'b1;
    tick();

    wr(16'hFFF0);
    chk("R11 upper write ignored", rd_data, exp_rd(0, 0, 0, 0, 3'b101));
    stat_in = 3'b010; #1;
    chk("R11 status field", rd_data, exp_rd(0, 0, 0, 0, 3'b010));
    wr(16'h000B);
    chk("R2 field write", rd_data, exp_rd(1, 0, 1, 1, 3'b010));
    rd_en = 1'b0; #1;
    chk("R2 read strobe low", rd_data, 16'h0);
    rd_en = 1'b1;
    wr(16'h0000);

    for (int i = 0; i < 8; i++) begin
      stop_mode = VEC[i][4];
      wr({12'b0, VEC[i][3], 2'b00, VEC[i][2]});
      chk("R7 regulator enable", {15'b0, reg_en_o}, {15'b0, VEC[i][1]});
      chk("R8 comparator enable", {15'b0, cmp_en_o}, {15'b0, VEC[i][0]});
    end
    stop_mode = 1'b0;
    wr(16'h0000);

    warn_raw = 1'b1;
    tick(2);
    chk("R3 flag not yet set", {15'b0, rd_data[2]}, 16'h0);
    tick();
    chk("R3 flag set", {15'b0, rd_data[2]}, 16'h1);
    chk("R6 irq masked by ie", {15'b0, irq_o}, 16'h0);
    wr(16'h0000);
    chk("R4 clear blocked by warning", {15'b0, rd_data[2]}, 16'h1);
    wr(16'h0002);
    chk("R6 irq flag&ie", {15'b0, irq_o}, 16'h1);
    warn_raw = 1'b0;
    tick(3);
    chk("R4 flag holds", {15'b0, rd_data[2]}, 16'h1);
    wr(16'h0002);
    chk("R4 clear works", {15'b0, rd_data[2]}, 16'h0);
    chk("R6 irq drops", {15'b0, irq_o}, 16'h0);

    wr(16'h0006);
    chk("R5 sw set flag", {15'b0, rd_data[2]}, 16'h1);
    chk("R5 sw set irq", {15'b0, irq_o}, 16'h1);
    wr(16'h0004);
    chk("R6 ie off", {15'b0, irq_o}, 16'h0);
    wr(16'h0000);

    rlvl_raw = 1'b1;
    tick();
    chk("R9 reset req delayed", {15'b0, pf_rst_o}, 16'h0);
    tick();
    chk("R9 reset req", {15'b0, pf_rst_o}, 16'h1);
    stop_mode = 1'b1;
    wr(16'h0001);
    chk("R9 reset req gated", {15'b0, pf_rst_o}, 16'h0);
    wr(16'h0000);
    chk("R9 stop monitor on", {15'b0, pf_rst_o}, 16'h1);

    wr(16'h0001);
    rlvl_raw = 1'b0; warn_raw = 1'b1;
    tick(4);
    chk("R10 warning ignored", {15'b0, rd_data[2]}, 16'h0);
    stop_mode = 1'b0;
    tick();
    chk("R10 warning after reenable", {15'b0, rd_data[2]}, 16'h1);
    warn_raw = 1'b0;
    tick(3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule